// File: doc/BRIEF.md
# Fixed-Latency Trigger Pipeline Buffer

This block sits behind a digitizer and holds recent history while a first-level trigger decision is being made. On every bunch-crossing clock it writes the incoming sample into a circular store, together with the sample's valid flag and a 12-bit crossing number. The store is written on every clock whatever the trigger does. A sample that is never accepted is never read back. It is overwritten when the write position comes round again.

The trigger decision for a crossing arrives a fixed number of clocks, L, after that crossing's sample. When an accept strobe arrives, the block reads the slot that lies exactly L positions behind the current write position. On the next clock it presents that sample and its crossing number to the derandomizer stage that follows.

L is taken from a configuration input, but only while reset is asserted. It is forced into a legal range and then held for the whole run, so the read position never jumps while data is flowing.

Top module: `trig_pipeline_buffer`

## Requirements
- R1: Outside reset, every clock writes the sample input and its valid flag into the next slot of the circular store, unconditionally, overwriting whatever that slot held.
- R2: The latency L is captured from `latencyCfg` on clocks where `rst_n` is low, and limited to the range 1 to `MAX_LAT`. A value of 0 becomes 1, and a value above `MAX_LAT` (default 200) becomes `MAX_LAT`.
- R3: Count clocks from 0 at the first edge with `rst_n` high. An accept sampled at clock k makes `outSample` equal the sample presented at clock k−L, visible after clock k. `outValid` is high for that one clock.
- R4: A crossing counter starts at 0 on clock 0, advances by one every clock and wraps modulo 4096. `outEventId` equals the counter value of the clock at which the extracted sample was written.
- R5: Changes of `latencyCfg` while `rst_n` is high have no effect on which sample is extracted.
- R6: `outValid` stays low for an accept whose target slot has not been written since reset (k < L), or whose stored valid flag is low.
- R7: `outValid` is low during reset. It is never high unless an accept was sampled on the clock before.
- R8: Accepts on consecutive clocks each produce their own output on consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Synchronous active-low reset; latency is captured while low |
| sampleIn | input | DATA_W | Digitized sample of the current crossing |
| sampleValid | input | 1 | Valid flag stored with the sample |
| trigAccept | input | 1 | First-level accept for the crossing L clocks earlier |
| latencyCfg | input | LAT_W | Requested trigger latency in clocks |
| outSample | output | DATA_W | Extracted sample |
| outEventId | output | ID_W | Crossing number of the extracted sample |
| outValid | output | 1 | One-clock strobe marking an extracted sample |

## Verification
The assertions assume that `latencyCfg` is steady for at least the last two clocks of reset, so that the captured latency does not move once the run starts. They also assume that `rst_n` changes only between clock edges. The stimulus sets the configuration before reset is asserted and holds reset low for three clocks. It then changes the configuration only after release, and only to exercise the rule that such changes are ignored. Accepts are issued from the first clock onward, so early accepts that point at slots not yet written are covered.

// File: rtl/tpb_pkg.sv
`timescale 1ns/1ps
package tpb_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } tpb_strobe_t;
endpackage

// File: rtl/tpb_ctrl.sv
`timescale 1ns/1ps
module tpb_ctrl
  import tpb_pkg::*;
#(
  parameter int DEPTH   = 256,
  parameter int MAX_LAT = 200,
  parameter int LAT_W   = 8,
  parameter int ID_W    = 12,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trigAccept,
  input  logic [LAT_W-1:0] latencyCfg,
  output tpb_strobe_t      strobes,
  output logic [AW-1:0]    wrAddr,
  output logic [AW-1:0]    rdAddr,
  output logic [ID_W-1:0]  eventId
);
  localparam logic [LAT_W-1:0] LAT_MAX_V = LAT_W'(MAX_LAT);
  localparam logic [LAT_W-1:0] LAT_MIN_V = LAT_W'(1);

  logic [LAT_W-1:0] latReg;

  function automatic logic [LAT_W-1:0] limitLat(input logic [LAT_W-1:0] req);
    if (req < LAT_MIN_V)      return LAT_MIN_V;
    else if (req > LAT_MAX_V) return LAT_MAX_V;
    else                      return req;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latReg  <= limitLat(latencyCfg);
      wrAddr  <= '0;
      eventId <= '0;
    end else begin
      wrAddr  <= wrAddr + AW'(1);
      eventId <= eventId + ID_W'(1);
    end
  end

  always_comb begin
    strobes.wrEn = rst_n;
    strobes.rdEn = rst_n & trigAccept;
    rdAddr       = wrAddr - AW'(latReg);
  end

  a_r2_latency_range: assert property (@(posedge clk) disable iff (!rst_n)
    (latReg >= LAT_MIN_V) && (latReg <= LAT_MAX_V));

  a_r5_latency_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(latReg));

  a_r4_id_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> eventId == $past(eventId) + ID_W'(1));

  a_r1_wr_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> wrAddr == $past(wrAddr) + AW'(1));
endmodule

// File: rtl/tpb_datapath.sv
`timescale 1ns/1ps
module tpb_datapath
  import tpb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ID_W   = 12,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH),
  localparam int WORD_W = DATA_W + ID_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tpb_strobe_t       strobes,
  input  logic [AW-1:0]     wrAddr,
  input  logic [AW-1:0]     rdAddr,
  input  logic [ID_W-1:0]   eventId,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic              sampleValid,
  output logic [DATA_W-1:0] outSample,
  output logic [ID_W-1:0]   outEventId,
  output logic              outValid
);
  logic [WORD_W-1:0] store [DEPTH];
  logic [DEPTH-1:0]  slotValid;

  always_ff @(posedge clk) begin
    if (strobes.wrEn) store[wrAddr] <= {eventId, sampleIn};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slotValid  <= '0;
      outValid   <= 1'b0;
      outSample  <= '0;
      outEventId <= '0;
    end else begin
      if (strobes.wrEn) slotValid[wrAddr] <= sampleValid;
      outValid <= strobes.rdEn & slotValid[rdAddr];
      if (strobes.rdEn) {outEventId, outSample} <= store[rdAddr];
    end
  end

  a_r7_valid_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && $past(rst_n)) |-> $past(strobes.rdEn));

  a_r3_no_collision: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.rdEn |-> rdAddr != wrAddr);

  a_r6_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !outValid);
endmodule

// File: rtl/trig_pipeline_buffer.sv
`timescale 1ns/1ps
module trig_pipeline_buffer
  import tpb_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ID_W    = 12,
  parameter int DEPTH   = 256,
  parameter int MAX_LAT = 200,
  parameter int LAT_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic              sampleValid,
  input  logic              trigAccept,
  input  logic [LAT_W-1:0]  latencyCfg,
  output logic [DATA_W-1:0] outSample,
  output logic [ID_W-1:0]   outEventId,
  output logic              outValid
);
  localparam int AW = $clog2(DEPTH);

  tpb_strobe_t     strobes;
  logic [AW-1:0]   wrAddr;
  logic [AW-1:0]   rdAddr;
  logic [ID_W-1:0] eventId;

  tpb_ctrl #(
    .DEPTH(DEPTH), .MAX_LAT(MAX_LAT), .LAT_W(LAT_W), .ID_W(ID_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .trigAccept(trigAccept), .latencyCfg(latencyCfg),
    .strobes(strobes), .wrAddr(wrAddr), .rdAddr(rdAddr), .eventId(eventId)
  );

  tpb_datapath #(
    .DATA_W(DATA_W), .ID_W(ID_W), .DEPTH(DEPTH)
  ) u_data (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .wrAddr(wrAddr),
    .rdAddr(rdAddr), .eventId(eventId), .sampleIn(sampleIn),
    .sampleValid(sampleValid), .outSample(outSample),
    .outEventId(outEventId), .outValid(outValid)
  );
endmodule

// File: tb/trig_pipeline_buffer_tb.sv
`timescale 1ns/1ps
module trig_pipeline_buffer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] sampleIn = '0;
  logic        sampleValid = 1'b0;
  logic        trigAccept = 1'b0;
  logic [7:0]  latencyCfg = 8'd160;
  logic [15:0] outSample;
  logic [11:0] outEventId;
  logic        outValid;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  typedef struct {
    int          cyc;
    bit          vld;
    logic [15:0] d;
    logic [11:0] id;
    string       req;
  } exp_t;
  exp_t expQ[$];

  logic [15:0] histD [512];
  bit          histV [512];

  always #4 clk = ~clk;

  trig_pipeline_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .sampleIn(sampleIn), .sampleValid(sampleValid),
    .trigAccept(trigAccept), .latencyCfg(latencyCfg), .outSample(outSample),
    .outEventId(outEventId), .outValid(outValid)
  );

  // monitor: samples 2 ns after each rising edge
  int mcyc = 0;
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (!rst_n) begin
        mcyc = 0;
        checks++;
        if (outValid !== 1'b0) begin
          fails++;
          $display("FAIL R7 reset: outValid=%b expected 0", outValid);
        end
      end else begin
        if (expQ.size() > 0 && expQ[0].cyc == mcyc) begin
          exp_t e;
          e = expQ.pop_front();
          checks++;
          if (outValid !== e.vld) begin
            fails++;
            $display("FAIL %s cyc %0d: outValid=%b expected %b", e.req, mcyc, outValid, e.vld);
          end else if (e.vld && (outSample !== e.d || outEventId !== e.id)) begin
            fails++;
            $display("FAIL %s cyc %0d: data=%h id=%0d expected data=%h id=%0d",
                     e.req, mcyc, outSample, outEventId, e.d, e.id);
          end
        end else begin
          checks++;
          if (outValid !== 1'b0) begin
            fails++;
            $display("FAIL R7 cyc %0d: outValid=%b without accept, expected 0", mcyc, outValid);
          end
        end
        mcyc++;
      end
    end
  end

  function automatic bit acceptAt(int mode, int cyc);
    if (mode == 0) return (cyc % 11 == 0) || ((cyc % 37) inside {5, 6, 7});
    else           return (cyc % 97 == 0) || (cyc >= 4290 && cyc < 4300);
  endfunction

  // driver: cfg is applied during reset, expL is the latency the requirements imply
  task automatic runPhase(input int cfg, input int expL, input int ncyc,
                          input int mode, input int seed, input int cfgChangeAt,
                          input string tag);
    @(negedge clk);
    rst_n = 1'b0;
    trigAccept = 1'b0;
    latencyCfg = 8'(cfg);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < ncyc; cyc++) begin
      logic [15:0] d;
      bit v;
      bit acc;
      d = 16'((cyc * 40503 + seed) & 16'hFFFF);
      v = (cyc % 5) != 3;
      sampleIn = d;
      sampleValid = v;
      histD[cyc % 512] = d;
      histV[cyc % 512] = v;
      acc = acceptAt(mode, cyc);
      trigAccept = acc;
      if (cyc == cfgChangeAt) latencyCfg = 8'd50;   // R5: must be ignored
      if (acc) begin
        exp_t e;
        e.cyc = cyc;
        e.req = tag;
        if (cyc < expL) begin
          e.vld = 1'b0; e.d = '0; e.id = '0; e.req = "R6";
        end else begin
          e.vld = histV[(cyc - expL) % 512];
          e.d   = histD[(cyc - expL) % 512];
          e.id  = 12'((cyc - expL) & 12'hFFF);
          if (!e.vld) e.req = "R6";
        end
        expQ.push_back(e);
      end
      @(negedge clk);
    end
    trigAccept = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    runPhase(160, 160, 600, 0, 11, 300, "R3");   // R3/R8 main, R5 change mid-run
    runPhase(1, 1, 300, 0, 901, -1, "R8");       // minimum latency, back-to-back
    runPhase(0, 1, 300, 0, 77, -1, "R2");        // 0 clamped to 1
    runPhase(255, 200, 500, 0, 5, -1, "R2");     // above MAX_LAT clamped
    runPhase(200, 200, 4400, 1, 333, -1, "R4");  // crossing-number wrap, R1 overwrite
    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R3: %0d expected outputs never seen, expected 0", expQ.size());
    end
    report();
  end

  initial begin
    #(8 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    report();
  end
endmodule